// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital half of a 10-bit successive-approximation converter. It holds the small register set that software uses to run the converter: a channel field and a start bit, a completion flag and an interrupt enable, and two read-only result registers. The analog comparator, trial DAC, input multiplexer and sample-and-hold sit outside the block. They connect only through digital ports: a comparator decision comes in, and a DAC trial code, a channel index and a hold request go out.

Software first writes the channel while the converter is idle and lets the input settle. It then writes the control register again with the start bit set. From that write the block runs a fixed 12-clock schedule. One cycle hands the sampled input over to the converter. Ten cycles each decide one result bit, most significant first. A last cycle commits the code to the result registers, drops the start bit and raises the completion flag. The interrupt output is the flag gated by its enable. Clearing the enable silences the interrupt while the flag stays readable.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After the synchronous active-low reset, every read register returns 0: start bit, channel, flag, enable and both result registers. irq and dac_code are also 0.
- R2: A write to address 0 with bit 0 set while the converter is idle starts a conversion. From the next cycle bit 0 of ctrl_rd reads 1 and hold_en is 1.
- R3: The search tests bits from the MSB down. The first trial code, on dac_code in the cycle after the handoff cycle, is half scale (0x200). The committed result is the largest code for which cmp_in reported input at or above the trial.
- R4: The result and the completion flag appear exactly 12 clocks after the clock edge that accepted the start write. One clock earlier the block is still busy and shows neither.
- R5: Hardware clears the start bit on the same edge that commits the result. No software action is needed.
- R6: The completion flag is bit 0 of address 1. It stays set until software writes address 1 with bit 0 equal to 0. Writing 1 there never sets it. If a clearing write lands on the completion edge, the flag ends up set.
- R7: irq is 1 exactly when the flag is set and the enable, bit 1 of address 1, is 1. Writing the enable to 0 drops irq and leaves the flag readable.
- R8: While a conversion runs, including on its completion edge, any write to address 0 is ignored. A new start neither restarts nor aborts the running conversion, and the channel does not change.
- R9: Both result registers hold their previous value for the whole conversion and change together on the completion edge.
- R10: res_hi (address 2) holds result bits 9..2. res_lo (address 3) holds result bits 1..0 in its bits 1..0, and its upper bits read 0. Writes to addresses 2 and 3 have no effect.
- R11: The channel field is bits 3..1 of address 0. It is driven on mux_sel and is the channel that gets converted. A write with bit 0 clear updates only the channel and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 control, 1 status, 2 result high, 3 result low) |
| cfg_wdata | input | 8 | Register write data |
| ctrl_rd | output | 8 | Control register: bit 0 start/busy, bits 3..1 channel |
| stat_rd | output | 8 | Status register: bit 0 completion flag, bit 1 interrupt enable |
| res_hi | output | 8 | Result bits 9..2 |
| res_lo | output | 8 | Result bits 1..0 in bits 1..0 |
| irq | output | 1 | Interrupt request, flag AND enable |
| cmp_in | input | 1 | Comparator: 1 when the sampled input is at or above dac_code |
| dac_code | output | 10 | Trial code for the external DAC |
| mux_sel | output | 3 | Channel index to the analog multiplexer |
| hold_en | output | 1 | Hold request to the sample-and-hold while converting |

## Verification
Count the edge that takes a start write as edge 0. The busy bit and mux_sel are due right after edge 0, and the half-scale trial after edge 1. Result, flag, cleared start bit and irq are due after edge 12, and register writes to the flag, enable or channel take effect after their own edge. The bench drives and samples on falling edges. It walks exactly eleven falling edges after the start to confirm that nothing has completed yet, then one more to confirm completion. A clearing write is placed so that its edge coincides with edge 12, and a second start lands on edge 3. Randomly chosen channels and input levels feed a comparator model in the bench, so every result is compared against the level that was set.

// File: rtl/sar_pkg.sv
// Shared constants for the conversion controller: default widths,
// register addresses and field positions within the control and status registers.
package sar_pkg;
    localparam int RES_W_D  = 10;   // converter resolution
    localparam int HI_W_D   = 8;    // bits held in the high result register
    localparam int CH_W_D   = 3;    // channel index width
    localparam int DATA_W_D = 8;    // register data width
    localparam int ADDR_W_D = 2;    // register address width

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_RHI  = 2'd2;
    localparam logic [1:0] ADR_RLO  = 2'd3;

    localparam int CTRL_GO_BIT = 0; // start / busy
    localparam int CTRL_CH_LSB = 1; // channel field lsb
    localparam int STAT_FLAG   = 0; // completion flag
    localparam int STAT_IEN    = 1; // interrupt enable
endpackage

// File: rtl/sar_seq.sv
// Conversion sequencer. Runs a fixed schedule of RES_W+2 cycles after go:
// phase 0 hands off from sampling, phases 1..RES_W decide one bit each
// (MSB first), and the last phase commits. Assumes go arrives only when idle.
module sar_seq #(
    parameter int RES_W = 10,
    parameter int BIT_W = $clog2(RES_W),
    parameter int STEPS = RES_W + 2,
    parameter int PH_W  = $clog2(STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    output logic             busy,
    output logic             first,
    output logic             decide,
    output logic             last,
    output logic [BIT_W-1:0] bit_idx
);
    logic [PH_W-1:0] phase_q;
    logic            run_q;
    logic [PH_W-1:0] down_w;

    // Phase counter: starts on go, wraps to idle after the commit phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            phase_q <= '0;
        end else if (go) begin
            run_q   <= 1'b1;
            phase_q <= '0;
        end else if (run_q) begin
            if (phase_q == PH_W'(STEPS - 1)) begin
                run_q   <= 1'b0;
                phase_q <= '0;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    // Phase decode into step strobes and the bit under test.
    always_comb begin
        busy    = run_q;
        first   = run_q && (phase_q == '0);
        decide  = run_q && (phase_q != '0) && (phase_q <= PH_W'(RES_W));
        last    = run_q && (phase_q == PH_W'(STEPS - 1));
        down_w  = PH_W'(RES_W) - phase_q;
        bit_idx = down_w[BIT_W-1:0];
    end
endmodule

// File: rtl/sar_approx.sv
// Successive-approximation register. Loads half scale on the handoff step,
// then on each decide step keeps or drops the bit under test according to the
// comparator and sets the next lower bit as the new trial. Holds otherwise.
module sar_approx #(
    parameter int RES_W = 10,
    parameter int BIT_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first,
    input  logic             decide,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             cmp_in,
    output logic [RES_W-1:0] trial
);
    logic [RES_W-1:0] trial_q;
    logic [RES_W-1:0] trial_nx;

    // Next trial: settle the tested bit, raise the one below it.
    always_comb begin
        trial_nx = trial_q;
        for (int i = 0; i < RES_W; i++) begin
            if (i == int'(bit_idx))     trial_nx[i] = cmp_in;
            if (i + 1 == int'(bit_idx)) trial_nx[i] = 1'b1;
        end
    end

    // Trial register update.
    always_ff @(posedge clk) begin
        if (!rst_n)      trial_q <= '0;
        else if (first)  trial_q <= {1'b1, {(RES_W-1){1'b0}}};
        else if (decide) trial_q <= trial_nx;
    end

    assign trial = trial_q;
endmodule

// File: rtl/sar_regs.sv
// Software-visible register state: channel, interrupt enable, sticky flag,
// and the committed result. Control writes are refused while busy.
// Assumes last is a single-cycle strobe carrying a settled trial code.
module sar_regs #(
    parameter int RES_W  = 10,
    parameter int CH_W   = 3,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              last,
    input  logic [RES_W-1:0]  trial,
    output logic              go,
    output logic [CH_W-1:0]   chan_q,
    output logic              ien_q,
    output logic              flag_q,
    output logic [RES_W-1:0]  result_q
);
    import sar_pkg::*;

    logic ctrl_wr;
    logic stat_wr;
    logic unused_wdata_bits;

    // Address decode; control writes only count while idle.
    always_comb begin
        ctrl_wr = wr && (addr == ADDR_W'(ADR_CTRL)) && !busy;
        stat_wr = wr && (addr == ADDR_W'(ADR_STAT));
        go      = ctrl_wr && wdata[CTRL_GO_BIT];
    end

    assign unused_wdata_bits = ^{wdata[DATA_W-1:CTRL_CH_LSB+CH_W]};

    // Channel field.
    always_ff @(posedge clk) begin
        if (!rst_n)       chan_q <= '0;
        else if (ctrl_wr) chan_q <= wdata[CTRL_CH_LSB +: CH_W];
    end

    // Interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n)       ien_q <= 1'b0;
        else if (stat_wr) ien_q <= wdata[STAT_IEN];
    end

    // Sticky completion flag; completion wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                            flag_q <= 1'b0;
        else if (last)                         flag_q <= 1'b1;
        else if (stat_wr && !wdata[STAT_FLAG]) flag_q <= 1'b0;
    end

    // Result commit, all bits at once.
    always_ff @(posedge clk) begin
        if (!rst_n)    result_q <= '0;
        else if (last) result_q <= trial;
    end
endmodule

// File: rtl/sar_conv_ctrl.sv
// Top level of the conversion controller. Ties the sequencer, the
// approximation register and the register set together and assembles the read
// views. Assumes cmp_in is a settled digital decision for the current dac_code.
module sar_conv_ctrl #(
    parameter int RES_W  = sar_pkg::RES_W_D,
    parameter int HI_W   = sar_pkg::HI_W_D,
    parameter int CH_W   = sar_pkg::CH_W_D,
    parameter int DATA_W = sar_pkg::DATA_W_D,
    parameter int ADDR_W = sar_pkg::ADDR_W_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [DATA_W-1:0] stat_rd,
    output logic [DATA_W-1:0] res_hi,
    output logic [DATA_W-1:0] res_lo,
    output logic              irq,
    input  logic              cmp_in,
    output logic [RES_W-1:0]  dac_code,
    output logic [CH_W-1:0]   mux_sel,
    output logic              hold_en
);
    import sar_pkg::*;

    localparam int LO_W  = RES_W - HI_W;
    localparam int BIT_W = $clog2(RES_W);

    logic             go, busy, first, decide, last;
    logic [BIT_W-1:0] bit_idx;
    logic [RES_W-1:0] trial;
    logic [CH_W-1:0]  chan_q;
    logic             ien_q, flag_q;
    logic [RES_W-1:0] result_q;

    sar_seq #(.RES_W(RES_W), .BIT_W(BIT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .first(first),
        .decide(decide), .last(last), .bit_idx(bit_idx)
    );

    sar_approx #(.RES_W(RES_W), .BIT_W(BIT_W)) u_approx (
        .clk(clk), .rst_n(rst_n), .first(first), .decide(decide),
        .bit_idx(bit_idx), .cmp_in(cmp_in), .trial(trial)
    );

    sar_regs #(.RES_W(RES_W), .CH_W(CH_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
        .busy(busy), .last(last), .trial(trial), .go(go), .chan_q(chan_q),
        .ien_q(ien_q), .flag_q(flag_q), .result_q(result_q)
    );

    // Read views: start bit mirrors the running sequencer.
    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[CTRL_GO_BIT] = busy;
        ctrl_rd[CTRL_CH_LSB +: CH_W] = chan_q;
        stat_rd = '0;
        stat_rd[STAT_FLAG] = flag_q;
        stat_rd[STAT_IEN]  = ien_q;
        res_hi = '0;
        res_hi[HI_W-1:0] = result_q[RES_W-1 -: HI_W];
        res_lo = '0;
        res_lo[LO_W-1:0] = result_q[LO_W-1:0];
    end

    // Analog-side and interrupt outputs.
    always_comb begin
        irq      = flag_q && ien_q;
        dac_code = trial;
        mux_sel  = chan_q;
        hold_en  = busy;
    end
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
// Property checker for sar_conv_ctrl, observing ports only; bound below.
module sar_conv_ctrl_chk #(
    parameter int RES_W  = 10,
    parameter int CH_W   = 3,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [DATA_W-1:0] ctrl_rd,
    input logic [DATA_W-1:0] stat_rd,
    input logic [DATA_W-1:0] res_hi,
    input logic [DATA_W-1:0] res_lo,
    input logic              irq,
    input logic [RES_W-1:0]  dac_code,
    input logic [CH_W-1:0]   mux_sel
);
    logic [7:0] busy_cnt;

    // Counts observed busy cycles of the current conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)          busy_cnt <= '0;
        else if (ctrl_rd[0]) busy_cnt <= busy_cnt + 1'b1;
        else                 busy_cnt <= '0;
    end

    // R4: a conversion is busy for exactly RES_W+2 cycles
    a_r4_fixed_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_rd[0]) |-> busy_cnt == 8'(RES_W + 2));

    // R3: first trial after the handoff cycle is half scale
    a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_rd[0]) |=> dac_code == {1'b1, {(RES_W-1){1'b0}}});

    // R5: the start bit only drops together with a set flag
    a_r5_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_rd[0]) |-> stat_rd[0]);

    // R6: flag only falls after a clearing status write
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_rd[0]) |-> $past(cfg_wr && cfg_addr == ADDR_W'(1) && !cfg_wdata[0]));

    // R7: interrupt needs both flag and enable
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_rd[0] && stat_rd[1]));

    // R9: results frozen while converting
    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[0] && $past(ctrl_rd[0])) |-> ($stable(res_hi) && $stable(res_lo)));

    // R8: channel cannot move during a conversion
    a_r8_chan_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[0] && $past(ctrl_rd[0])) |-> $stable(mux_sel));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(
    .RES_W(RES_W), .CH_W(CH_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ctrl_rd(ctrl_rd), .stat_rd(stat_rd),
    .res_hi(res_hi), .res_lo(res_lo), .irq(irq), .dac_code(dac_code),
    .mux_sel(mux_sel)
);

// File: tb/tb_sar_conv_ctrl.sv
module tb_sar_conv_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_wr;
    logic [1:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic [7:0] ctrl_rd, stat_rd, res_hi, res_lo;
    logic       irq, cmp_in, hold_en;
    logic [9:0] dac_code;
    logic [2:0] mux_sel;

    logic [9:0] ana [8];
    int checks = 0;
    int fails  = 0;
    bit ien_m  = 1'b0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Comparator model: input at or above trial code.
    assign cmp_in = (ana[mux_sel] >= dac_code);

    sar_conv_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ctrl_rd(ctrl_rd), .stat_rd(stat_rd),
        .res_hi(res_hi), .res_lo(res_lo), .irq(irq), .cmp_in(cmp_in),
        .dac_code(dac_code), .mux_sel(mux_sel), .hold_en(hold_en)
    );

    function automatic logic [7:0] exp_hi(input logic [9:0] v);
        return v[9:2];
    endfunction
    function automatic logic [7:0] exp_lo(input logic [9:0] v);
        return {6'b0, v[1:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One register write; called at a falling edge, returns one falling edge later.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    // Full conversion with timing checks; flag cleared first.
    task automatic conv(input int ch);
        logic [7:0] oh, ol;
        wr(2'd1, {6'b0, ien_m, 1'b0});
        oh = res_hi; ol = res_lo;
        wr(2'd0, {4'b0, 3'(ch), 1'b1});
        chk(ctrl_rd[0] == 1'b1 && hold_en, "R2 busy after start", ctrl_rd, 1);
        chk(mux_sel == 3'(ch), "R11 mux_sel", mux_sel, ch);
        @(negedge clk);
        chk(dac_code == 10'h200, "R3 half-scale trial", dac_code, 10'h200);
        repeat (10) @(negedge clk);
        chk(ctrl_rd[0] == 1'b1 && stat_rd[0] == 1'b0, "R4 not done at 11", {ctrl_rd, stat_rd}, 16'h0100);
        chk(res_hi == oh && res_lo == ol, "R9 result held", {res_hi, res_lo}, {oh, ol});
        @(negedge clk);
        chk(res_hi == exp_hi(ana[ch]), "R3 R10 res_hi", res_hi, exp_hi(ana[ch]));
        chk(res_lo == exp_lo(ana[ch]), "R10 res_lo", res_lo, exp_lo(ana[ch]));
        chk(stat_rd[0] == 1'b1, "R4 R6 flag at 12", stat_rd, 1);
        chk(ctrl_rd[0] == 1'b0, "R5 start self-clear", ctrl_rd, 0);
        chk(irq == ien_m, "R7 irq", irq, ien_m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) ana[i] = 10'($urandom);
        ana[5] = 10'h3FF; ana[2] = 10'h000; ana[1] = 10'h155; ana[6] = 10'h2AA;
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ctrl_rd, stat_rd, res_hi, res_lo} == '0 && !irq && dac_code == '0, "R1 reset state",
            {ctrl_rd, stat_rd, res_hi, res_lo}, 0);

        // Full scale and zero corners, interrupt enabled.
        ien_m = 1'b1;
        conv(5);
        conv(2);

        // R6: writing 1 to flag does not set it; writing 0 clears.
        wr(2'd1, 8'h02);
        chk(stat_rd[0] == 1'b0 && !irq, "R6 clear", stat_rd, 8'h02);
        wr(2'd1, 8'h03);
        chk(stat_rd[0] == 1'b0, "R6 write one ignored", stat_rd, 8'h02);

        // R6: clear landing on completion edge loses.
        wr(2'd0, {4'b0, 3'd3, 1'b1});
        repeat (11) @(negedge clk);
        wr(2'd1, 8'h02);
        chk(stat_rd[0] == 1'b1, "R6 completion beats clear", stat_rd, 1);
        chk(res_hi == exp_hi(ana[3]), "R6 collision result", res_hi, exp_hi(ana[3]));

        // R7: enable gates irq, flag stays.
        wr(2'd1, 8'h01);
        chk(!irq && stat_rd[0], "R7 enable off masks irq", {irq, stat_rd}, 9'h001);
        wr(2'd1, 8'h03);
        chk(irq == 1'b1, "R7 enable on", irq, 1);

        // R8: second start mid-conversion ignored.
        wr(2'd1, 8'h02);
        wr(2'd0, {4'b0, 3'd1, 1'b1});
        repeat (2) @(negedge clk);
        wr(2'd0, {4'b0, 3'd6, 1'b1});
        chk(mux_sel == 3'd1 && ctrl_rd[3:1] == 3'd1, "R8 channel kept", mux_sel, 1);
        repeat (8) @(negedge clk);
        chk(ctrl_rd[0] && !stat_rd[0], "R8 no early finish", {ctrl_rd[0], stat_rd[0]}, 2'b10);
        @(negedge clk);
        chk(stat_rd[0] && res_hi == exp_hi(ana[1]) && res_lo == exp_lo(ana[1]), "R8 original conversion",
            {res_hi, res_lo}, {exp_hi(ana[1]), exp_lo(ana[1])});
        @(negedge clk);
        chk(!ctrl_rd[0], "R8 no restart", ctrl_rd, 0);

        // R11: channel-only write starts nothing.
        wr(2'd1, 8'h02);
        wr(2'd0, {4'b0, 3'd4, 1'b0});
        chk(ctrl_rd == 8'h08 && mux_sel == 3'd4 && !hold_en, "R11 channel only", ctrl_rd, 8'h08);
        repeat (13) @(negedge clk);
        chk(stat_rd[0] == 1'b0, "R11 no conversion", stat_rd, 8'h02);

        // R10: result registers not writable.
        begin
            logic [7:0] h, l;
            h = res_hi; l = res_lo;
            wr(2'd2, 8'hA5);
            wr(2'd3, 8'hFF);
            chk(res_hi == h && res_lo == l, "R10 result write ignored", {res_hi, res_lo}, {h, l});
        end

        // Random conversions, random enable.
        for (int n = 0; n < 40; n++) begin
            int ch;
            ch = int'($urandom_range(0, 7));
            ana[ch] = 10'($urandom);
            ien_m = 1'($urandom);
            conv(ch);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule